// File: doc/BRIEF.md
# Reloadable Down-Counter Timer Channel

This block is a single programmable timer channel. A host loads a 16-bit preset over a byte-wide register port. The preset goes into a down-counter on any of several initialization events. The counter then steps down once per count enable. When it passes zero it reloads itself from the preset, sets a sticky interrupt flag and updates a wave output. With a 2 MHz count enable and a preset of 499, the flag rises once every 250 microseconds, so software can keep a real-time clock from the tick.

The counter can run as one 16-bit counter, in which case the output is a square wave with half-period N+1. It can also run as two chained 8-bit counters, which gives a wave with a programmable duty cycle. The count enable is either the internal E tick or the rising edges of an external clock. The external clock is synchronized and then counted on the E tick. A gate input, also synchronized, holds the count while it is high and restarts the channel on its falling edge.

Top module: `tmr_channel`

## Requirements
- R1: After reset the preset and the counter both hold 0xFFFF, the control register reads 0, and `irq` and `waveOut` are low.
- R2: A write to address 1 stores a pending high byte and leaves the counter unchanged. A write to address 2 forms the preset from {pending byte, written byte} and loads the counter in the same clock. A write to address 3 has no effect.
- R3: Initialization copies the preset into the counter and clears the flag. It happens on reset, on a preset low-byte write, on a falling edge of the gate seen after two synchronizer flops, and continuously while control bit 0 is 1. While bit 0 is 1 the counter does not count.
- R4: In 16-bit mode (control bit 2 = 0) the counter decrements once per count enable. An enable at zero reloads the preset and sets the flag, so after initialization with preset N the flag first rises N+1 enables later.
- R5: In 16-bit mode `waveOut` toggles on every reload, so each half-period lasts N+1 enables. Initialization returns `waveOut` to 0.
- R6: In dual 8-bit mode (control bit 2 = 1) with preset high byte M and low byte L, the period is (M+1)(L+1) enables. `waveOut` is high for the last L+1 enables of each period, and the flag sets once per period.
- R7: Control bit 1 selects the count enable: 0 selects `eTick`, 1 selects the synchronized rising edges of `extClk`. Each external edge is held pending until an `eTick` and then counts exactly once.
- R8: While the synchronized gate is high the counter holds its value.
- R9: `irq` equals the flag and stays set until it is cleared. It clears only when a read of address 1 (counter high byte) follows a read of address 0 (status) made while the flag was set. A counter read alone leaves it set.
- R10: Read map: address 0 gives status (bit 0 = flag), address 1 the counter high byte, address 2 the counter low byte, and address 3 the control register. Address 0 is also the control-write address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| eTick | input | 1 | Internal count enable pulse |
| extClk | input | 1 | External clock, asynchronous |
| gateIn | input | 1 | Gate: high holds, falling edge restarts |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Register read strobe (read side effects) |
| rdAddr | input | 2 | Read address |
| rdData | output | 8 | Read data, combinational from rdAddr |
| irq | output | 1 | Interrupt, active high, sticky |
| waveOut | output | 1 | Square or variable-duty wave |

## Verification
On every cycle the assertions check the datapath's step rules: an initialization loads the preset and clears the flag, an enabled count decrements or wraps with a flag and a toggle, the counter is stable without an enable, the flag is sticky, and a synchronized gate fall initializes. Only the bench scenarios show the behaviour that builds up over many cycles. That covers flag latency and toggle periods swept over presets, duty and period in split mode across a grid of bytes, period stretching under a sparse tick, and external edges being counted one each. It also covers the two-read clear sequence and the byte ordering of preset writes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int ADDR_W = 2;
  localparam int CTRL_W = 3;

  // control register bit positions
  localparam int HOLD_BIT = 0;
  localparam int SRC_BIT  = 1;
  localparam int DUAL_BIT = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;  // write: control, read: status
  localparam logic [ADDR_W-1:0] ADDR_HI   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_LO   = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CRD  = 2'd3;  // read: control

  typedef struct packed {
    logic              initLoad;
    logic              cntEn;
    logic              wrHi;
    logic              wrLo;
    logic              clrFlag;
    logic              dualMode;
    logic [BYTE_W-1:0] data;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic syncOut,
  output logic prevOut
);
  logic [STAGES:0] shreg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shreg <= {(STAGES+1){RESET_VAL}};
    else       shreg <= {shreg[STAGES-1:0], din};
  end

  assign syncOut = shreg[STAGES-1];
  assign prevOut = shreg[STAGES];
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eTick,
  input  logic              extClk,
  input  logic              gateIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              flagQ,
  output tmrStrobe_t        strobe,
  output logic [CTRL_W-1:0] ctrlQ
);
  logic gSync, gPrev, eSync, ePrev;
  logic gateFall, gateOpen, extRise, extPend, extTick, srcTick;
  logic statusSeen;

  tmr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) uGateSync (
    .clk(clk), .rstN(rstN), .din(gateIn), .syncOut(gSync), .prevOut(gPrev));

  tmr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) uExtSync (
    .clk(clk), .rstN(rstN), .din(extClk), .syncOut(eSync), .prevOut(ePrev));

  assign gateFall = gPrev & ~gSync;
  assign gateOpen = ~gSync;
  assign extRise  = eSync & ~ePrev;
  assign extTick  = extPend & eTick;
  assign srcTick  = ctrlQ[SRC_BIT] ? extTick : eTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ      <= '0;
      extPend    <= 1'b0;
      statusSeen <= 1'b0;
    end else begin
      if (wrEn && wrAddr == ADDR_CTRL) ctrlQ <= wrData[CTRL_W-1:0];
      extPend <= extRise | (extPend & ~eTick);
      if (strobe.initLoad || strobe.clrFlag)         statusSeen <= 1'b0;
      else if (rdEn && rdAddr == ADDR_CTRL && flagQ) statusSeen <= 1'b1;
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.wrHi     = wrEn && (wrAddr == ADDR_HI);
    strobe.wrLo     = wrEn && (wrAddr == ADDR_LO);
    strobe.initLoad = strobe.wrLo | ctrlQ[HOLD_BIT] | gateFall;
    strobe.cntEn    = srcTick & gateOpen & ~ctrlQ[HOLD_BIT];
    strobe.clrFlag  = rdEn && (rdAddr == ADDR_HI) && statusSeen;
    strobe.dualMode = ctrlQ[DUAL_BIT];
    strobe.data     = wrData;
  end

  p_gate_fall_init_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gSync) |-> strobe.initLoad);
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  output logic [CNT_W-1:0] cntQ,
  output logic             flagQ,
  output logic             waveOut
);
  logic [CNT_W-1:0]  latchQ, cntD;
  logic [BYTE_W-1:0] msbBuf, hiVal, loVal;
  logic              toggleQ, toggleD, flagD, flagSet;
  logic              loZero, wrapAll;

  assign hiVal   = cntQ[CNT_W-1:BYTE_W];
  assign loVal   = cntQ[BYTE_W-1:0];
  assign loZero  = (loVal == '0);
  assign wrapAll = (cntQ == '0);

  always_comb begin
    cntD    = cntQ;
    toggleD = toggleQ;
    flagSet = 1'b0;
    if (strobe.initLoad) begin
      cntD    = strobe.wrLo ? {msbBuf, strobe.data} : latchQ;
      toggleD = 1'b0;
    end else if (strobe.cntEn) begin
      if (strobe.dualMode) begin
        if (wrapAll) begin
          cntD    = latchQ;
          flagSet = 1'b1;
        end else if (loZero) begin
          cntD = {BYTE_W'(hiVal - 1'b1), latchQ[BYTE_W-1:0]};
        end else begin
          cntD = {hiVal, BYTE_W'(loVal - 1'b1)};
        end
      end else begin
        if (wrapAll) begin
          cntD    = latchQ;
          flagSet = 1'b1;
          toggleD = ~toggleQ;
        end else begin
          cntD = CNT_W'(cntQ - 1'b1);
        end
      end
    end
    if (strobe.initLoad)     flagD = 1'b0;
    else if (flagSet)        flagD = 1'b1;
    else if (strobe.clrFlag) flagD = 1'b0;
    else                     flagD = flagQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ  <= '1;
      msbBuf  <= '1;
      cntQ    <= '1;
      flagQ   <= 1'b0;
      toggleQ <= 1'b0;
    end else begin
      if (strobe.wrHi) msbBuf <= strobe.data;
      if (strobe.wrLo) latchQ <= {msbBuf, strobe.data};
      cntQ    <= cntD;
      flagQ   <= flagD;
      toggleQ <= toggleD;
    end
  end

  assign waveOut = strobe.dualMode ? (hiVal == '0) : toggleQ;

  p_init_copies_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.initLoad |=> cntQ == latchQ);
  p_init_clears_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.initLoad |=> !flagQ);
  p_dec_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntEn && !strobe.initLoad && !strobe.dualMode && cntQ != '0
      |=> cntQ == CNT_W'($past(cntQ) - 1'b1));
  p_wrap_reload_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntEn && !strobe.initLoad && !strobe.dualMode && cntQ == '0
      |=> flagQ && cntQ == latchQ);
  p_wrap_toggle_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntEn && !strobe.initLoad && !strobe.dualMode && cntQ == '0
      |=> toggleQ != $past(toggleQ));
  p_dual_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntEn && !strobe.initLoad && strobe.dualMode && cntQ == '0
      |=> flagQ && cntQ == latchQ);
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.cntEn && !strobe.initLoad |=> $stable(cntQ));
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    flagQ && !strobe.clrFlag && !strobe.initLoad |=> flagQ);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eTick,
  input  logic              extClk,
  input  logic              gateIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BYTE_W-1:0] rdData,
  output logic              irq,
  output logic              waveOut
);
  tmrStrobe_t        strobe;
  logic [CNT_W-1:0]  cntQ;
  logic [CTRL_W-1:0] ctrlQ;
  logic              flagQ;

  tmr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .eTick(eTick), .extClk(extClk), .gateIn(gateIn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdEn(rdEn), .rdAddr(rdAddr),
    .flagQ(flagQ), .strobe(strobe), .ctrlQ(ctrlQ));

  tmr_datapath uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cntQ(cntQ), .flagQ(flagQ),
    .waveOut(waveOut));

  always_comb begin
    unique case (rdAddr)
      ADDR_CTRL: rdData = {{(BYTE_W-1){1'b0}}, flagQ};
      ADDR_HI:   rdData = cntQ[CNT_W-1:BYTE_W];
      ADDR_LO:   rdData = cntQ[BYTE_W-1:0];
      default:   rdData = {{(BYTE_W-CTRL_W){1'b0}}, ctrlQ};
    endcase
  end

  assign irq = flagQ;
endmodule

// File: tb/tb_tmr_channel.sv
module tb_tmr_channel;
  logic clk = 0, rstN = 0, eTick = 0, extClk = 0, gateIn = 0;
  logic wrEn = 0, rdEn = 0;
  logic [1:0] wrAddr = 0, rdAddr = 0;
  logic [7:0] wrData = 0, rdData;
  logic irq, waveOut;
  int checks = 0, errors = 0, tickMode = 0, phase = 0;

  tmr_channel dut (.*);

  always #5 clk = ~clk;

  // count-enable generator: 0 off, 1 every cycle, 3 every third cycle
  always @(negedge clk) begin
    #1;
    phase = (phase + 1) % 3;
    eTick = (tickMode == 1) || (tickMode == 3 && phase == 0);
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rdEn = 1; rdAddr = a; #2 d = rdData;
    @(negedge clk); rdEn = 0;
  endtask

  task automatic peek(output logic [15:0] v);
    #2 rdAddr = 1; #1 v[15:8] = rdData; rdAddr = 2; #1 v[7:0] = rdData;
  endtask

  task automatic setLatch(input logic [15:0] v);
    wr(1, v[15:8]); wr(2, v[7:0]);
  endtask

  task automatic waitFlag(output int k);
    k = 0;
    while (!irq && k < 5000) begin @(negedge clk); k++; end
  endtask

  task automatic measureToggle(output int k);
    logic o;
    int g;
    g = 0; o = waveOut;
    while (waveOut == o && g < 5000) begin @(negedge clk); g++; end
    o = waveOut; k = 0;
    while (waveOut == o && k < 5000) begin @(negedge clk); k++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v, v0;
    logic [7:0] d;
    int k;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    peek(v);
    check("R1", "counter after reset", v, 16'hFFFF);
    check("R1", "irq after reset", irq, 0);
    check("R1", "waveOut after reset", waveOut, 0);
    rd(3, d);
    check("R1", "control after reset", d, 0);

    // R2 byte ordering
    setLatch(16'h1234); peek(v);
    check("R2", "preset load", v, 16'h1234);
    wr(1, 8'hAB); peek(v);
    check("R2", "high byte alone no effect", v, 16'h1234);
    wr(3, 8'h55); peek(v);
    check("R2", "address 3 write ignored", v, 16'h1234);
    wr(2, 8'hCD); peek(v);
    check("R2", "low byte completes preset", v, 16'hABCD);

    // R10 read map
    wr(0, 8'h04); rd(3, d);
    check("R10", "control readback", d, 4);
    wr(0, 8'h00); rd(0, d);
    check("R10", "status flag clear", d, 0);

    // R4 / R5 sweep of presets in 16-bit mode
    tickMode = 1;
    for (int n = 0; n <= 10; n++) begin
      int nn;
      nn = (n == 10) ? 37 : n;
      setLatch(16'(nn));
      waitFlag(k);
      check("R4", $sformatf("flag latency N=%0d", nn), k, nn + 1);
      measureToggle(k);
      check("R5", $sformatf("half period N=%0d", nn), k, nn + 1);
    end
    rd(0, d);
    check("R10", "status flag set", d, 1);

    // R4 with sparse tick
    tickMode = 3;
    setLatch(16'd4);
    measureToggle(k);
    check("R4", "half period with tick every third cycle", k, 15);
    tickMode = 1;

    // R6 dual 8-bit sweep
    wr(0, 8'h04);
    for (int m = 0; m < 4; m++) begin
      for (int l = 0; l < 4; l++) begin
        int h;
        setLatch({8'(m), 8'(l)});
        waitFlag(k);
        check("R6", $sformatf("dual period M=%0d L=%0d", m, l), k, (m + 1) * (l + 1));
        h = 0;
        for (int i = 0; i < (m + 1) * (l + 1); i++) begin
          @(negedge clk); if (waveOut) h++;
        end
        check("R6", $sformatf("dual high time M=%0d L=%0d", m, l), h, l + 1);
      end
    end
    wr(0, 8'h00);

    // R3 hold via control bit 0
    setLatch(16'd50);
    repeat (5) @(negedge clk);
    wr(0, 8'h01);
    repeat (10) @(negedge clk);
    peek(v);
    check("R3", "hold keeps preset", v, 50);
    check("R3", "hold clears flag", irq, 0);
    wr(0, 8'h00);
    repeat (10) @(negedge clk);
    peek(v);
    check("R3", "count resumes after hold", v, 40);

    // R8 gate holds, R3 gate fall reloads
    setLatch(16'd200);
    repeat (20) @(negedge clk);
    tickMode = 0;
    repeat (2) @(negedge clk);
    peek(v0);
    gateIn = 1;
    repeat (4) @(negedge clk);
    tickMode = 1;
    repeat (10) @(negedge clk);
    tickMode = 0;
    repeat (2) @(negedge clk);
    peek(v);
    check("R8", "gate high holds counter", v, v0);
    gateIn = 0;
    repeat (4) @(negedge clk);
    peek(v);
    check("R3", "gate fall reloads preset", v, 200);

    // R7 external clock
    tickMode = 1;
    wr(0, 8'h02);
    setLatch(16'd300);
    repeat (3) @(negedge clk);
    for (int p = 0; p < 5; p++) begin
      extClk = 1; repeat (3) @(negedge clk);
      extClk = 0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    peek(v);
    check("R7", "five external edges", v, 295);
    tickMode = 0;
    extClk = 1; repeat (3) @(negedge clk);
    extClk = 0; repeat (4) @(negedge clk);
    peek(v);
    check("R7", "edge waits for tick", v, 295);
    tickMode = 1;
    repeat (4) @(negedge clk);
    peek(v);
    check("R7", "pending edge counted once", v, 294);
    wr(0, 8'h00);

    // R9 interrupt clearing
    setLatch(16'd3);
    waitFlag(k);
    tickMode = 0;
    repeat (20) @(negedge clk);
    check("R9", "irq sticky", irq, 1);
    rd(1, d);
    check("R9", "counter read alone keeps irq", irq, 1);
    rd(0, d);
    check("R9", "status read keeps irq", irq, 1);
    rd(1, d);
    check("R9", "status then counter read clears", irq, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule